// File: doc/BRIEF.md
# Byte-Masked Write Controller for a Word-Only SRAM

This block sits between a cache-side request bus and a single-port SRAM that can only store whole words. Every request moves a full word. A write carries a word address, a data word and one enable bit per byte lane. When every lane is enabled, the word goes straight into the SRAM in the cycle it is accepted. When only some lanes are enabled, the controller first reads the stored word. It then replaces the enabled lanes, writes the merged word back and only then accepts the next request. A write with no lanes enabled is accepted and leaves the SRAM untouched.

A read returns the whole stored word on the response port one cycle after it is accepted. A requester that holds a read pending while a merge sequence is running waits on `req_ready`. Because of that, the read always sees the merged word. The SRAM has a one-cycle read latency and is modelled inside the block.

The control machine has four states:
- `ST_IDLE`: ready is high and requests are accepted.
- `ST_RD_RESP`: the read response is presented.
- `ST_MERGE`: the merged word is written.
- `ST_SETTLE`: the machine returns to idle.

It has these transitions:
- IDLE to RD_RESP on an accepted read.
- IDLE to MERGE on an accepted partial write.
- IDLE to IDLE on an accepted full write, an accepted empty write, or no request.
- RD_RESP to IDLE.
- MERGE to SETTLE.
- SETTLE to IDLE.

Top module: `rmw_sram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A write with mask 4'b1111 is stored in the cycle it is accepted, and `req_ready` stays 1 with no stall cycle.
- R3: A write whose mask is neither 4'b0000 nor 4'b1111 holds `req_ready` at 0 for exactly the two cycles after its acceptance, then raises it again.
- R4: Mask bit i selects byte lane i, which is data bits [8i+7:8i]. After a partial write, enabled lanes hold the write data and disabled lanes keep their stored value, including for non-contiguous masks.
- R5: Aligned byte writes (mask 4'b0001) and aligned halfword writes (mask 4'b0011 or 4'b1100) take the stalling merge path of R3.
- R6: A write of lanes 1 to 3 leaves stored lane 0 unchanged. A following write of lane 0 of the next word leaves that word's lanes 1 to 3 unchanged.
- R7: A write with mask 4'b0000 is accepted with no stall cycle and leaves the stored word unchanged.
- R8: An accepted read gives `rsp_valid` = 1 in the next cycle, for one cycle, with the full stored word on `rsp_rdata`. `req_ready` is 0 during that cycle.
- R9: A read held pending during a merge sequence is accepted only after the sequence ends, and it returns the merged word.
- R10: `rsp_valid` is 1 only in the cycle after an accepted read, and never in response to a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | DATA_W (32) | Write data word |
| req_mask | input | DATA_W/8 (4) | Byte-lane enables for writes |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W (32) | Full stored word |

## Verification
A state machine stuck in or skipping a merge state shows up at once as the wrong number of cycles with `req_ready` low after a partial, full or empty write. The check therefore counts the stall cycles of every write. A wrong merge lane, a wrong capture of the held address, or a write issued on the wrong path stays hidden in the SRAM. It becomes visible on the next read of that word, one cycle after that read is accepted. Every write is therefore followed by a read-back against an independent byte-lane model. A spurious or missing read response appears on `rsp_valid` in the cycle after acceptance, and `rsp_valid` is watched during writes as well.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_RESP = 2'd1,
        ST_MERGE   = 2'd2,
        ST_SETTLE  = 2'd3
    } ctrl_state_e;
endpackage

// File: rtl/rmw_word_sram.sv
// Single-port word-wide storage: no lane enables, one-cycle read latency.
module rmw_word_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
        if (en && !we) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/rmw_lane_merge.sv
// Per-lane select between new write data and the stored word.
module rmw_lane_merge #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]   old_word,
    input  logic [DATA_W-1:0]   new_word,
    input  logic [DATA_W/8-1:0] lane_en,
    output logic [DATA_W-1:0]   merged
);
    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[8*g +: 8] = lane_en[g] ? new_word[8*g +: 8] : old_word[8*g +: 8];
    end
endmodule

// File: rtl/rmw_ctrl_fsm.sv
// Control machine: path choice per request, stall during merge.
module rmw_ctrl_fsm
    import rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic mask_full,
    input  logic mask_none,
    output logic req_ready,
    output logic rsp_valid,
    output logic hold_req,
    output logic sram_en,
    output logic sram_we,
    output logic use_merge
);
    ctrl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        hold_req  = 1'b0;
        sram_en   = 1'b0;
        sram_we   = 1'b0;
        use_merge = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    if (!req_write) begin
                        sram_en = 1'b1;
                        state_d = ST_RD_RESP;
                    end else if (mask_full) begin
                        sram_en = 1'b1;
                        sram_we = 1'b1;
                    end else if (!mask_none) begin
                        sram_en  = 1'b1;
                        hold_req = 1'b1;
                        state_d  = ST_MERGE;
                    end
                end
            end
            ST_RD_RESP: begin
                rsp_valid = 1'b1;
                state_d   = ST_IDLE;
            end
            ST_MERGE: begin
                sram_en   = 1'b1;
                sram_we   = 1'b1;
                use_merge = 1'b1;
                state_d   = ST_SETTLE;
            end
            ST_SETTLE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/rmw_sram_ctrl.sv
module rmw_sram_ctrl #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_mask,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata
);
    localparam int LANES = DATA_W / 8;

    logic              hold_req, sram_en, sram_we, use_merge;
    logic              mask_full, mask_none;
    logic [ADDR_W-1:0] held_addr, sram_addr;
    logic [DATA_W-1:0] held_data, sram_wdata, sram_rdata, merged;
    logic [LANES-1:0]  held_mask;

    assign mask_full = &req_mask;
    assign mask_none = ~|req_mask;

    rmw_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .mask_full (mask_full),
        .mask_none (mask_none),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .hold_req  (hold_req),
        .sram_en   (sram_en),
        .sram_we   (sram_we),
        .use_merge (use_merge)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_data <= '0;
            held_mask <= '0;
        end else if (hold_req) begin
            held_addr <= req_addr;
            held_data <= req_wdata;
            held_mask <= req_mask;
        end
    end

    rmw_lane_merge #(.DATA_W(DATA_W)) u_merge (
        .old_word (sram_rdata),
        .new_word (held_data),
        .lane_en  (held_mask),
        .merged   (merged)
    );

    assign sram_addr  = use_merge ? held_addr : req_addr;
    assign sram_wdata = use_merge ? merged : req_wdata;

    rmw_word_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sram (
        .clk   (clk),
        .en    (sram_en),
        .we    (sram_we),
        .addr  (sram_addr),
        .wdata (sram_wdata),
        .rdata (sram_rdata)
    );

    assign rsp_rdata = sram_rdata;
endmodule

// File: rtl/rmw_sram_ctrl_chk.sv
module rmw_sram_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_write,
    input logic [DATA_W/8-1:0] req_mask,
    input logic                rsp_valid
);
    logic acc_rd, acc_full, acc_none, acc_part;
    assign acc_rd   = req_valid && req_ready && !req_write;
    assign acc_full = req_valid && req_ready && req_write && (&req_mask);
    assign acc_none = req_valid && req_ready && req_write && !(|req_mask);
    assign acc_part = req_valid && req_ready && req_write && (|req_mask) && !(&req_mask);

    AST_FULL_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_full |=> req_ready); // R2
    AST_PART_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_part |=> !req_ready ##1 !req_ready ##1 req_ready); // R3
    AST_EMPTY_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        acc_none |=> req_ready); // R7
    AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rsp_valid && !req_ready); // R8
    AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_rd)); // R10
endmodule

bind rmw_sram_ctrl rmw_sram_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_mask  (req_mask),
    .rsp_valid (rsp_valid)
);

// File: tb/rmw_sram_ctrl_tb_top.sv
module rmw_sram_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [3:0]    req_mask = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    logic [DW-1:0] model [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    rmw_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    function automatic logic [DW-1:0] lane_mix(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w,
                                                input logic [3:0] m);
        logic [DW-1:0] r;
        for (int i = 0; i < 4; i++) begin
            r[8*i +: 8] = m[i] ? new_w[8*i +: 8] : old_w[8*i +: 8];
        end
        return r;
    endfunction

    // Issue a write, count ready-low cycles afterwards, watch for stray responses.
    task automatic do_write(input string req, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic [3:0] m,
                            input int exp_stall);
        int stall = 0;
        int stray = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && stall < 10) begin
            if (rsp_valid) stray++;
            stall++;
            @(negedge clk);
        end
        if (rsp_valid) stray++;
        check({req, " stall"}, DW'(stall), DW'(exp_stall));
        check("R10 no response to write", DW'(stray), '0);
        model[a[3:0]] = lane_mix(model[a[3:0]], d, m);
    endtask

    task automatic do_read(input string req, input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 rsp_valid", DW'(rsp_valid), 1);
        check("R8 ready low in response", DW'(req_ready), 0);
        check({req, " read data"}, rsp_rdata, model[a[3:0]]);
        @(negedge clk);
        check("R8 single-cycle response", DW'(rsp_valid), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ready after reset", DW'(req_ready), 1);
        check("R1 rsp_valid after reset", DW'(rsp_valid), 0);
    endtask

    task automatic t_full();
        do_write("R2", 6'd3, 32'hA1B2C3D4, 4'b1111, 0);
        do_read("R2", 6'd3);
        do_write("R2", 6'd3, 32'h0F1E2D3C, 4'b1111, 0);
        do_read("R2", 6'd3);
    endtask

    task automatic t_partial();
        for (int i = 4; i < 8; i++) do_write("R2 preset", AW'(i), 32'h11223344 * i, 4'b1111, 0);
        do_write("R5 byte", 6'd4, 32'hDEADBEEF, 4'b0001, 2);
        do_read("R4 byte", 6'd4);
        do_write("R5 low half", 6'd5, 32'hCAFEF00D, 4'b0011, 2);
        do_read("R4 low half", 6'd5);
        do_write("R5 high half", 6'd6, 32'h89ABCDEF, 4'b1100, 2);
        do_read("R4 high half", 6'd6);
        do_write("R3 sparse", 6'd7, 32'h55AA66BB, 4'b0101, 2);
        do_read("R4 sparse", 6'd7);
        do_write("R3 sparse", 6'd7, 32'h77CC88DD, 4'b1010, 2);
        do_read("R4 sparse", 6'd7);
    endtask

    task automatic t_example();
        do_write("R2 preset", 6'd8, 32'h11223344, 4'b1111, 0);
        do_write("R2 preset", 6'd9, 32'h55667788, 4'b1111, 0);
        do_write("R6 lanes 1-3", 6'd8, 32'hAABBCCDD, 4'b1110, 2);
        do_write("R6 lane 0", 6'd9, 32'h000000EE, 4'b0001, 2);
        do_read("R6 first word", 6'd8);
        check("R6 literal first", model[8], 32'hAABBCC44);
        do_read("R6 next word", 6'd9);
        check("R6 literal next", model[9], 32'h556677EE);
    endtask

    task automatic t_empty();
        do_write("R2 preset", 6'd10, 32'h13579BDF, 4'b1111, 0);
        do_write("R7 empty mask", 6'd10, 32'hFFFFFFFF, 4'b0000, 0);
        do_read("R7 unchanged", 6'd10);
    endtask

    // Read held pending while the merge runs.
    task automatic t_read_behind_merge();
        int waited = 0;
        do_write("R2 preset", 6'd11, 32'h00000000, 4'b1111, 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd11;
        req_wdata = 32'h12345678; req_mask = 4'b0110;
        @(posedge clk);
        @(negedge clk);
        model[11] = lane_mix(model[11], 32'h12345678, 4'b0110);
        req_write = 1'b0;
        while (!req_ready && waited < 10) begin
            waited++;
            @(negedge clk);
        end
        check("R9 read waited for merge", DW'(waited), 2);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 response valid", DW'(rsp_valid), 1);
        check("R9 merged data", rsp_rdata, 32'h00345600);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full();
        t_partial();
        t_example();
        t_empty();
        t_read_behind_merge();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule